// File: doc/BRIEF.md
# Multiplexed Keypad Reader with Interrupt

This block is the key-matrix register of a small handheld controller port. Eight key inputs arrive as an active-high vector: the four direction keys in the upper nibble, the four action buttons in the lower nibble. Software writes two select bits that choose what the low nibble of the register shows: the direction group, the button group, both groups merged, or the index of the active multiplayer controller. The low nibble reads active-low, so a pressed key reads as 0. The upper two bits always read 1.

The select bits form a four-state machine with these states: MODE_MERGE (select 00), MODE_BUTTONS (select 01), MODE_DIRS (select 10) and MODE_INDEX (select 11). There is one transition, LOAD, taken on any write; it moves to the state named by write-data bits 5:4. The machine holds its state on every other cycle. Reset enters MODE_INDEX.

The selected nibble is evaluated again on every clock cycle. A one-cycle interrupt request is raised whenever any of the four lines goes from 1 to 0. That can come from a key press while its group is selected, from a change of select, or from a write: a write is compared against an all-high nibble. An optional filter hides opposite direction pairs that are pressed together. It acts on the read value only, never on the interrupt.

Top module: `keypad_mux`

## Requirements
- R1: After reset the register reads 0xFF and the interrupt request is low.
- R2: A write keeps only write-data bits 5:4 as the select, and these read back at bits 5:4. Bits 7:6 always read 1, and the written bits 7:6 and 3:0 have no effect on the read value.
- R3: With select 10 (write 0x20) the low nibble reads the bitwise inverse of key bits 7:4.
- R4: With select 01 (write 0x10) the low nibble reads the inverse of key bits 3:0.
- R5: With select 00 the low nibble reads the inverse of (key bits 7:4 OR key bits 3:0).
- R6: With select 11 the low nibble reads the inverse of the controller index, zero-extended to four bits.
- R7: While the controller index is non-zero, all local keys are treated as released.
- R8: The read value and the interrupt both reflect a change one clock edge after it is applied. The interrupt is a one-cycle pulse raised when any low-nibble line goes from 1 to 0.
- R9: A line going from 0 to 1 (a key release) raises no interrupt.
- R10: A write is evaluated against an all-high low nibble, so rewriting the select while a selected key is held raises an interrupt.
- R11: With the opposite-direction filter on and select 10, a pair (bits 1:0 or bits 3:2) that would read 00 reads 11 instead. Each pair is handled separately. The filter does not apply with other selects and does not affect the interrupt.
- R12: With the filter off, a pressed opposite pair reads 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; only bits 5:4 are used |
| keys | input | 8 | Pressed keys, active high; directions in 7:4, buttons in 3:0 |
| ctrl_idx | input | 2 | Active multiplayer controller index |
| block_opposites | input | 1 | Enables the opposite-direction filter |
| rd_data | output | 8 | Register read value |
| irq | output | 1 | One-cycle keypad interrupt request |

## Verification
Each select is driven with key vectors that differ between the two nibbles (0x05, 0x90, 0x12). This makes a swapped group, a missing OR, or an inverted nibble read wrongly. Controller index values of 0 and 2 separate index display from key masking. Press, release and re-write sequences show whether the interrupt is tied to falling edges only and whether a write uses the all-high baseline. Filter patterns press one pair, both pairs and a single key, under both selects and with the filter on and off.

// File: rtl/kp_pkg.sv
package kp_pkg;
    typedef enum logic [1:0] {
        MODE_MERGE   = 2'b00,
        MODE_BUTTONS = 2'b01,
        MODE_DIRS    = 2'b10,
        MODE_INDEX   = 2'b11
    } kp_mode_e;
endpackage

// File: rtl/kp_group_select.sv
module kp_group_select
    import kp_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int IDX_W = 2
) (
    input  kp_mode_e               mode,
    input  logic [KEY_W-1:0]       keys,
    input  logic [IDX_W-1:0]       idx,
    output logic [KEY_W/2-1:0]     lines
);
    localparam int NIB_W = KEY_W / 2;

    logic [KEY_W-1:0] local_keys;
    logic [NIB_W-1:0] picked;

    always_comb begin
        // R7: a remote controller owns the port, local keys look released
        local_keys = (idx != '0) ? '0 : keys;
        picked     = '0;
        unique case (mode)
            MODE_MERGE:   picked = local_keys[KEY_W-1:NIB_W] | local_keys[NIB_W-1:0];
            MODE_BUTTONS: picked = local_keys[NIB_W-1:0];
            MODE_DIRS:    picked = local_keys[KEY_W-1:NIB_W];
            MODE_INDEX:   picked = NIB_W'(idx);
        endcase
        lines = ~picked;
    end
endmodule

// File: rtl/kp_fall_detect.sv
module kp_fall_detect #(
    parameter int LINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LINE_W-1:0] next_lines,
    output logic [LINE_W-1:0] lines_q,
    output logic              irq_q
);
    logic [LINE_W-1:0] base;

    always_comb base = load ? '1 : lines_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lines_q <= '1;
            irq_q   <= 1'b0;
        end else begin
            lines_q <= next_lines;
            irq_q   <= |(base & ~next_lines);
        end
    end

    // R8: every pulse is explained by a write or by a line that fell
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ($past(load) || (($past(lines_q) & ~lines_q) != '0)));

    // R9: with no write and no falling line there is no pulse
    p_no_rise_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && (($past(lines_q) & ~lines_q) == '0)) |-> !irq_q);
endmodule

// File: rtl/kp_opposite_mask.sv
module kp_opposite_mask
    import kp_pkg::*;
#(
    parameter int LINE_W = 4
) (
    input  logic              en,
    input  kp_mode_e          mode,
    input  logic [LINE_W-1:0] raw,
    output logic [LINE_W-1:0] masked
);
    localparam int PAIRS = LINE_W / 2;

    logic active;
    assign active = en && (mode == MODE_DIRS);

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign masked[2*p+1:2*p] = (active && raw[2*p+1:2*p] == 2'b00) ? 2'b11 : raw[2*p+1:2*p];
        always_comb begin
            if (active) begin
                p_pair_masked_r11: assert (masked[2*p+1:2*p] != 2'b00);
            end
        end
    end
endmodule

// File: rtl/keypad_mux.sv
module keypad_mux
    import kp_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [KEY_W-1:0] keys,
    input  logic [IDX_W-1:0] ctrl_idx,
    input  logic             block_opposites,
    output logic [7:0]       rd_data,
    output logic             irq
);
    localparam int NIB_W = KEY_W / 2;

    kp_mode_e         mode_q, mode_next;
    logic [NIB_W-1:0] next_lines, lines_q, shown;

    // state register: reset enters MODE_INDEX, LOAD on every write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_INDEX;
        else        mode_q <= mode_next;
    end

    always_comb mode_next = wr_en ? kp_mode_e'(wr_data[5:4]) : mode_q;

    kp_group_select #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_select (
        .mode  (mode_next),
        .keys  (keys),
        .idx   (ctrl_idx),
        .lines (next_lines)
    );

    kp_fall_detect #(.LINE_W(NIB_W)) u_fall (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr_en),
        .next_lines (next_lines),
        .lines_q    (lines_q),
        .irq_q      (irq)
    );

    kp_opposite_mask #(.LINE_W(NIB_W)) u_mask (
        .en     (block_opposites),
        .mode   (mode_q),
        .raw    (lines_q),
        .masked (shown)
    );

    // output process
    always_comb rd_data = {2'b11, mode_q, shown};

    p_high_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:6] == 2'b11);

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> rd_data[5:4] == $past(rd_data[5:4]));

    p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[5:4] == $past(wr_data[5:4]));
endmodule

// File: tb/keypad_mux_bench.sv
module keypad_mux_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] keys = 8'h00;
    logic [1:0] ctrl_idx = 2'd0;
    logic       block_opposites = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    keypad_mux u_keypad_mux (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .keys(keys), .ctrl_idx(ctrl_idx), .block_opposites(block_opposites),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // write at a falling edge, result visible at the next falling edge
    task automatic write_reg(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_keys(input logic [7:0] k);
        keys = k;
        @(negedge clk);
    endtask

    task automatic settle();
        @(negedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 read", rd_data, 8'hFF);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_select_bits();
        write_reg(8'hC5); settle();
        check("R2 merge no keys", rd_data, 8'hCF);
        write_reg(8'h1A); settle();
        check("R2 buttons no keys", rd_data, 8'hDF);
        write_reg(8'h3F); settle();
        check("R2 index", rd_data, 8'hFF);
    endtask

    task automatic t_buttons_and_irq();
        write_reg(8'h10); settle();
        set_keys(8'h05);
        check("R4 buttons", rd_data, 8'hDA);
        check("R8 pulse", {7'd0, irq}, 8'h01);
        @(negedge clk);
        check("R8 pulse ends", {7'd0, irq}, 8'h00);
        set_keys(8'h00);
        check("R9 release value", rd_data, 8'hDF);
        check("R9 no irq on release", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_dirs_merge();
        write_reg(8'h20); settle();
        set_keys(8'h90); settle();
        check("R3 dirs", rd_data, 8'hE6);
        write_reg(8'h00); settle();
        set_keys(8'h12); settle();
        check("R5 merge", rd_data, 8'hCC);
        set_keys(8'h00); settle();
    endtask

    task automatic t_index();
        ctrl_idx = 2'd2;
        write_reg(8'h30); settle();
        check("R6 index 2", rd_data, 8'hFD);
        write_reg(8'h10);
        set_keys(8'h0F); @(negedge clk);
        check("R7 keys masked", rd_data, 8'hDF);
        check("R7 no irq", {7'd0, irq}, 8'h00);
        ctrl_idx = 2'd0; settle();
        set_keys(8'h00); settle();
    endtask

    task automatic t_rewrite();
        write_reg(8'h10);
        set_keys(8'h01); settle();
        check("R10 idle no irq", {7'd0, irq}, 8'h00);
        write_reg(8'h10);
        check("R10 rewrite irq", {7'd0, irq}, 8'h01);
        check("R10 value", rd_data, 8'hDE);
        set_keys(8'h00); settle();
    endtask

    task automatic t_filter();
        block_opposites = 1'b1;
        write_reg(8'h20); settle();
        set_keys(8'h30);
        check("R11 pair hidden", rd_data, 8'hEF);
        check("R11 irq unaffected", {7'd0, irq}, 8'h01);
        set_keys(8'hF0); @(negedge clk);
        check("R11 both pairs", rd_data, 8'hEF);
        set_keys(8'h10); @(negedge clk);
        check("R11 single key", rd_data, 8'hEE);
        write_reg(8'h10);
        set_keys(8'h03); @(negedge clk);
        check("R11 not in buttons", rd_data, 8'hDC);
        block_opposites = 1'b0;
        write_reg(8'h20);
        set_keys(8'h30); @(negedge clk);
        check("R12 filter off", rd_data, 8'hEC);
        set_keys(8'h00); settle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select_bits();
        t_buttons_and_irq();
        t_dirs_merge();
        t_index();
        t_rewrite();
        t_filter();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule